// File: doc/BRIEF.md
# Paged Boot-Swap Memory Decoder

This block produces chip selects for an 8-bit processor with a 16-bit address bus whose attached memory exceeds 64 KB. A small page register extends the address. The upper half of the space, 0x8000 to 0xFFFF, is the same in every page. The lower half, 0x0000 to 0x7FFF, shows one of four pages picked by two page bits. The selects are active high and one-hot. They cover eight 16 KB main flash segments, four 8 KB boot EEPROM segments, a 2 KB SRAM and a 256-byte control window. A separate active-low select serves one external device.

Two further bits of the page register support in-field updates. After reset the swap bit is clear, so the top 16 KB of memory is boot EEPROM and the reset vector is fetched from there. Setting swap moves flash segment 7 into the top of memory and moves the boot EEPROM into page 3. In page 3 the boot EEPROM is reachable only while the unlock bit is set, which protects the displaced boot code. The processor writes and reads the page register at a fixed address inside the control window. Address decoding is purely combinational. Among overlapping regions, fixed tiers decide which select wins: SRAM, control window and external device first, then boot EEPROM, then main flash.

Top module: `pbs_decoder`

## Requirements
- R1: After reset every page-register bit is 0. A read of the register address 0x8A00 returns 0x00, and address 0xFFFE selects boot EEPROM segment 1 (eep_sel bit 1).
- R2: The page register is loaded from wr_data on a clock edge where wr_stb is 1 and addr is 0x8A00. Bit 7 is swap, bit 6 is unlock, and bits 1:0 are the page number. It reads back on rd_data at 0x8A00 with bits 5:2 as 0. rd_data is 0x00 at every other address. A strobe to any other address leaves the register unchanged.
- R3: In every page and every swap/unlock state, the common regions decode as follows. flash_sel bit 0 covers 0x9000–0xBFFF, sram_sel covers 0x8200–0x89FF, ctl_sel covers 0x8A00–0x8AFF, and ext_sel_n is 0 for 0x8C00–0x8FFF.
- R4: Flash segments 1 to 6 decode in the lower half by page. Page p (p = 0, 1, 2) selects segment 2p+1 at 0x0000–0x3FFF and segment 2p+2 at 0x4000–0x7FFF.
- R5: With swap=0, boot EEPROM segment 0 is selected at 0xC000–0xDFFF and segment 1 at 0xE000–0xFFFF in every page. Flash segment 7 is selected at 0x4000–0x7FFF in page 3 only.
- R6: With swap=1, flash segment 7 is selected at 0xC000–0xFFFF in every page. Boot EEPROM segments 0 and 1 are selected at 0x4000–0x5FFF and 0x6000–0x7FFF in page 3, and only while unlock=1. With unlock=0 those addresses select nothing.
- R7: In page 3, EEPROM segment 2 is selected at 0x0000–0x1FFF and segment 3 at 0x2000–0x3FFF, whatever the state of swap and unlock.
- R8: For any address and register state, at most one of the internal selects (flash_sel, eep_sel, sram_sel, ctl_sel) is active. Addresses in no region, such as 0x8000–0x81FF and 0x8B00–0x8BFF, leave every select inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the page register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address |
| wr_stb | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 8 | Write data for the page register |
| rd_data | output | 8 | Page register value at its address, 0x00 elsewhere |
| flash_sel | output | 8 | Main flash segment selects, active high |
| eep_sel | output | 4 | Boot EEPROM segment selects, active high |
| sram_sel | output | 1 | SRAM select, active high |
| ctl_sel | output | 1 | Control window select, active high |
| ext_sel_n | output | 1 | External device select, active low |

## Verification
The selects and rd_data depend on addr through combinational logic only. The bench therefore samples them a few nanoseconds after it changes addr, with no clock edge in between. A page-register write takes effect at the rising edge where the strobe is sampled. The bench drives the write at a falling edge and does its next check no earlier than the following falling edge. That check reads the register back and sweeps each region boundary in all sixteen register states. Random addresses under random register states are then compared against a reference map function.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int FLASH_N  = 8;
  localparam int EEP_N    = 4;
  localparam int PAGE_W   = 2;
  localparam int PAGED_FL = 3;  // pages carrying flash pairs

  localparam int SWAP_BIT   = 7;
  localparam int UNLOCK_BIT = 6;

  localparam logic [ADDR_W-1:0] CTL_BASE = 16'h8A00;

  typedef struct packed {
    logic             swap;
    logic             unlock;
    logic [PAGE_W-1:0] page;
  } pgreg_t;

  typedef struct packed {
    logic [FLASH_N-1:0] flash;
    logic [EEP_N-1:0]   eep;
    logic               sram;
    logic               ctl;
    logic               ext;
  } sel_t;
endpackage

// File: rtl/pbs_page_reg.sv
module pbs_page_reg
  import pbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output pgreg_t            q
);
  logic [1:0] rst_sync;
  logic       rst_ok;
  pgreg_t     q_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  always_comb begin
    q_nxt = q;
    if (wr_en) begin
      q_nxt.swap   = wdata[SWAP_BIT];
      q_nxt.unlock = wdata[UNLOCK_BIT];
      q_nxt.page   = wdata[PAGE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) q <= '0;
    else         q <= q_nxt;
  end

  // R2: a write lands in the register on the next edge
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_en |=> (q.swap == $past(wdata[SWAP_BIT])) && (q.page == $past(wdata[PAGE_W-1:0])));
  // R2: without a write the register holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/pbs_region_dec.sv
module pbs_region_dec
  import pbs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  pgreg_t            pg,
  output sel_t              raw
);
  logic [PAGED_FL-1:0] lo_hit, hi_hit;
  logic                lower, pg3;

  assign lower = !addr[ADDR_W-1];
  assign pg3   = (pg.page == 2'd3);

  for (genvar p = 0; p < PAGED_FL; p++) begin : g_paged
    assign lo_hit[p] = lower && !addr[ADDR_W-2] && (pg.page == PAGE_W'(p));
    assign hi_hit[p] = lower &&  addr[ADDR_W-2] && (pg.page == PAGE_W'(p));
  end

  always_comb begin
    raw = '0;
    raw.flash[0] = (addr >= 16'h9000) && (addr <= 16'hBFFF);
    for (int p = 0; p < PAGED_FL; p++) begin
      raw.flash[2*p+1] = lo_hit[p];
      raw.flash[2*p+2] = hi_hit[p];
    end
    raw.flash[7] = pg.swap ? (addr[15:14] == 2'b11)
                           : (pg3 && addr[15:14] == 2'b01);
    raw.eep[0] = pg.swap ? (pg.unlock && pg3 && addr[15:13] == 3'b010)
                         : (addr[15:13] == 3'b110);
    raw.eep[1] = pg.swap ? (pg.unlock && pg3 && addr[15:13] == 3'b011)
                         : (addr[15:13] == 3'b111);
    raw.eep[2] = pg3 && addr[15:13] == 3'b000;
    raw.eep[3] = pg3 && addr[15:13] == 3'b001;
    raw.sram   = (addr >= 16'h8200) && (addr <= 16'h89FF);
    raw.ctl    = addr[15:8] == CTL_BASE[15:8];
    raw.ext    = addr[15:10] == 6'b100011;
  end
endmodule

// File: rtl/pbs_prio_mask.sv
module pbs_prio_mask
  import pbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sel_t raw,
  output sel_t sel
);
  logic tier1, tier2;

  assign tier1 = raw.sram | raw.ctl | raw.ext;
  assign tier2 = |raw.eep;

  always_comb begin
    sel       = raw;
    sel.eep   = tier1 ? '0 : raw.eep;
    sel.flash = (tier1 || tier2) ? '0 : raw.flash;
  end

  // R8: a flash select never coexists with a higher tier request
  a_r8_tiers: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel.flash) |-> !(|raw.eep) && !raw.sram && !raw.ctl && !raw.ext);
endmodule

// File: rtl/pbs_decoder.sv
module pbs_decoder
  import pbs_pkg::*;
#(
  parameter logic [7:0] PGREG_OFS = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        wr_stb,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  output logic [7:0]  flash_sel,
  output logic [3:0]  eep_sel,
  output logic        sram_sel,
  output logic        ctl_sel,
  output logic        ext_sel_n
);
  localparam logic [ADDR_W-1:0] PGREG_ADDR = CTL_BASE | {8'h00, PGREG_OFS};

  pgreg_t pg;
  sel_t   raw, sel;
  logic   reg_hit;

  assign reg_hit = (addr == PGREG_ADDR);

  pbs_page_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_stb && reg_hit), .wdata(wr_data), .q(pg)
  );
  pbs_region_dec u_dec (.addr(addr), .pg(pg), .raw(raw));
  pbs_prio_mask  u_mask (.clk(clk), .rst_n(rst_n), .raw(raw), .sel(sel));

  assign rd_data   = reg_hit ? {pg.swap, pg.unlock, 4'b0000, pg.page} : 8'h00;
  assign flash_sel = sel.flash;
  assign eep_sel   = sel.eep;
  assign sram_sel  = sel.sram;
  assign ctl_sel   = sel.ctl;
  assign ext_sel_n = !sel.ext;

  // R8: internal selects are one-hot or idle
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flash_sel, eep_sel, sram_sel, ctl_sel}));
  // R6: boot code in page 3 is reachable only when unlocked
  a_r6_unlock_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (pg.swap && (|eep_sel[1:0])) |-> (pg.unlock && pg.page == 2'd3));
  // R5: with swap clear the reset vector comes from boot EEPROM
  a_r5_reset_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg.swap && addr == 16'hFFFE) |-> eep_sel[1]);
  // R3: the external select excludes the internal ones
  a_r3_ext_alone: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_sel_n |-> !(|{flash_sel, eep_sel, sram_sel, ctl_sel}));
endmodule

// File: tb/test_pbs_decoder.sv
module test_pbs_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        wr_stb;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic [7:0]  flash_sel;
  logic [3:0]  eep_sel;
  logic        sram_sel, ctl_sel, ext_sel_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pbs_decoder i_pbs_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_data(rd_data), .flash_sel(flash_sel), .eep_sel(eep_sel),
    .sram_sel(sram_sel), .ctl_sel(ctl_sel), .ext_sel_n(ext_sel_n)
  );

  // Reference map: {flash[7:0], eep[3:0], sram, ctl, ext_n}
  function automatic logic [14:0] ref_map(input int a, input int pg, input bit sw, input bit ul);
    logic [7:0] f = '0;
    logic [3:0] e = '0;
    logic s = 0, c = 0, x = 0;
    if (a < 'h8000) begin
      if (pg < 3) begin
        if (a < 'h4000) f[2*pg+1] = 1; else f[2*pg+2] = 1;
      end else begin
        if (a < 'h2000)      e[2] = 1;
        else if (a < 'h4000) e[3] = 1;
        else if (!sw)        f[7] = 1;
        else if (ul)         e[(a < 'h6000) ? 0 : 1] = 1;
      end
    end else begin
      if (a >= 'h8200 && a < 'h8A00)      s = 1;
      else if (a >= 'h8A00 && a < 'h8B00) c = 1;
      else if (a >= 'h8C00 && a < 'h9000) x = 1;
      else if (a >= 'h9000 && a < 'hC000) f[0] = 1;
      else if (a >= 'hC000) begin
        if (sw) f[7] = 1;
        else    e[(a < 'hE000) ? 0 : 1] = 1;
      end
    end
    return {f, e, s, c, !x};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h addr=%h", req, act, exp, addr);
    end
  endtask

  task automatic write_reg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic probe(input string req, input int a, input int pg, input bit sw, input bit ul);
    addr = 16'(a);
    #2;
    chk(req, 32'({flash_sel, eep_sel, sram_sel, ctl_sel, ext_sel_n}), 32'(ref_map(a, pg, sw, ul)));
  endtask

  initial begin
    #3000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    rst_n = 1'b0; addr = 16'h0000; wr_stb = 1'b0; wr_data = 8'h00;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    addr = 16'h8A00; #2;
    chk("R1 rd", 32'(rd_data), 32'h00);
    probe("R1 vec", 'hFFFE, 0, 0, 0);
    chk("R1 eep1", 32'(eep_sel), 32'h2);

    // R2: write elsewhere ignored, write without strobe ignored
    write_reg(16'h8A01, 8'hFF);
    addr = 16'h8A00; #2;
    chk("R2 other addr", 32'(rd_data), 32'h00);
    @(negedge clk); addr = 16'h8A00; wr_data = 8'hFF; wr_stb = 1'b0;
    @(negedge clk); #2;
    chk("R2 no strobe", 32'(rd_data), 32'h00);
    write_reg(16'h8A00, 8'hFF);
    addr = 16'h8A00; #2;
    chk("R2 readback", 32'(rd_data), 32'hC3);
    addr = 16'h8A01; #2;
    chk("R2 rd other", 32'(rd_data), 32'h00);

    // Directed boundary sweep across all sixteen register states (R3..R8)
    for (int st = 0; st < 16; st++) begin
      int pg = st & 3;
      bit sw = st[3];
      bit ul = st[2];
      write_reg(16'h8A00, {sw, ul, 4'b0000, 2'(pg)});
      addr = 16'h8A00; #2;
      chk("R2 state", 32'(rd_data), 32'({sw, ul, 4'b0000, 2'(pg)}));
      for (int b = 0; b < 256; b++) begin
        probe("R3-8 lo", b * 256, pg, sw, ul);
        probe("R3-8 hi", b * 256 + 255, pg, sw, ul);
      end
    end

    // Named spot checks
    write_reg(16'h8A00, 8'h01);
    probe("R4 page1 seg3", 'h1234, 1, 0, 0);
    probe("R3 sram", 'h8200, 1, 0, 0);
    probe("R3 ext", 'h8C00, 1, 0, 0);
    probe("R8 hole", 'h8B80, 1, 0, 0);
    write_reg(16'h8A00, 8'h83);
    probe("R6 locked", 'h4000, 3, 1, 0);
    probe("R6 top flash7", 'hFFFE, 3, 1, 0);
    probe("R7 eep2", 'h0000, 3, 1, 0);
    write_reg(16'h8A00, 8'hC3);
    probe("R6 unlocked eep1", 'h7FFF, 3, 1, 1);
    write_reg(16'h8A00, 8'h03);
    probe("R5 flash7 pg3", 'h5000, 3, 0, 0);

    // Random register states and addresses
    for (int r = 0; r < 300; r++) begin
      logic [7:0] v = 8'($urandom);
      write_reg(16'h8A00, v);
      for (int k = 0; k < 20; k++)
        probe("R3-8 rand", int'($urandom & 32'hFFFF), int'(v[1:0]), v[7], v[6]);
    end

    // R1: reset again clears the register
    rst_n = 1'b0; #5; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    addr = 16'h8A00; #2;
    chk("R1 re-reset", 32'(rd_data), 32'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule